// File: doc/BRIEF.md
# Receive statistics counter bank

This block keeps three wide receive-side error counters for an Ethernet receive path and exposes them through a small 32-bit register port. Once per received frame the MAC presents a frame-end pulse together with the frame's length (destination and source address, payload and the four CRC bytes) and a CRC-error flag. Undersized frames with a CRC error are counted as fragments and oversized frames with a CRC error as jabbers. A separate FCS-error indication is counted once per pulse.

Software reads each counter as two 32-bit words. A configuration word lets software zero every counter at once. It can also freeze a consistent copy of all counters: the readable values stay fixed while the live counters keep counting. A build-time switch removes the counters entirely, leaving reads of the counter words at zero.

Internally a two-state snapshot controller (LIVE, FROZEN) selects whether reads come from the live counters or from the shadow copy. The transition LIVE to FROZEN is taken on a write that raises the snapshot bit, and the shadow is loaded in that same cycle. The transition FROZEN to LIVE is taken on a write that lowers the snapshot bit. Every other cycle stays in the current state.

Top module: `rx_stat_bank`

## Requirements
- R1: On a cycle with `frame_end`=1 and `frame_crc_err`=1, the fragment counter advances by one when `frame_len` < MIN_LEN (default 64). A length of exactly MIN_LEN, or a frame without the error flag, leaves it unchanged.
- R2: On a cycle with `frame_end`=1 and `frame_crc_err`=1, the jabber counter advances by one when `frame_len` > MAX_LEN (default 1518). A length of exactly MAX_LEN, or an oversized frame without the error flag, leaves it unchanged.
- R3: The FCS counter advances by one for each low-to-high transition of `fcs_err`, however many cycles the input stays high.
- R4: Register map (12-bit word address): fragments low/high at 0x900/0x901, jabbers at 0x902/0x903, FCS at 0x904/0x905, configuration at 0x945. Read data appears on `reg_rdata` in the cycle after `reg_rd` is sampled and holds until the next read. Any other address reads as 0.
- R5: Each counter is CNT_W bits wide (default 64) and wraps to zero after its maximum value instead of saturating.
- R6: Reading a counter, any number of times, leaves its value unchanged.
- R7: A write to 0x945 with bit 0 set zeroes all counters in that cycle. A counting event in the same cycle is lost, and the counter ends at zero. Bit 0 reads back as 0.
- R8: A write to 0x945 that sets bit 2 while it is clear copies all counters at once. While bit 2 stays set, counter reads return the copied values, the live counters keep counting, and bit 2 reads back as 1.
- R9: A write to 0x945 that clears bit 2 makes counter reads return the live values again, including every event counted while frozen.
- R10: With STATS_EN=0, no counters exist and every read of 0x900 to 0x905 returns 0.
- R11: After reset, all counters and the configuration word read as 0 and reads come from the live counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_end | input | 1 | One-cycle pulse at the end of each received frame |
| frame_len | input | LEN_W | Frame length in bytes, addresses through CRC |
| frame_crc_err | input | 1 | CRC-error flag, valid with `frame_end` |
| fcs_err | input | 1 | FCS-error indication; each rising edge counts once |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |

## Verification
Frames are sent at lengths on both sides of each threshold (below MIN_LEN, at MIN_LEN, at MAX_LEN, above MAX_LEN), each with and without the CRC flag. These cases separate the two size classes from each other and from frames that have no error. FCS pulses of one cycle, of several cycles and back to back show whether edges or high cycles are being counted. Another case lands a clear and a counting event on the same edge to show which one wins. Frames sent while a snapshot is held show whether the frozen view and the live count diverge and whether they reconnect on release. Separate builds with narrow counters and with the counters removed show the wrap and the zero read.

// File: rtl/rx_stat_pkg.sv
package rx_stat_pkg;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] ADDR_CNT_BASE = 12'h900;
    localparam logic [ADDR_W-1:0] ADDR_CFG      = 12'h945;

    localparam int CFG_CLR_BIT  = 0;
    localparam int CFG_SNAP_BIT = 2;

    localparam int NUM_CNT = 3;
    localparam int READ_W  = 64;

    typedef enum logic [1:0] {
        CNT_FRAG = 2'd0,
        CNT_JAB  = 2'd1,
        CNT_FCS  = 2'd2
    } cnt_id_e;

    typedef enum logic {
        SNAP_LIVE   = 1'b0,
        SNAP_FROZEN = 1'b1
    } snap_state_e;

endpackage

// File: rtl/rx_stat_classify.sv
module rx_stat_classify
    import rx_stat_pkg::*;
#(
    parameter int LEN_W   = 16,
    parameter int MIN_LEN = 64,
    parameter int MAX_LEN = 1518
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frame_end,
    input  logic [LEN_W-1:0]     frame_len,
    input  logic                 frame_crc_err,
    input  logic                 fcs_err,
    output logic [NUM_CNT-1:0]   cnt_ev
);

    localparam logic [LEN_W-1:0] MIN_L = LEN_W'(MIN_LEN);
    localparam logic [LEN_W-1:0] MAX_L = LEN_W'(MAX_LEN);

    logic fcs_q;
    logic bad_frame;
    logic is_short;
    logic is_long;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fcs_q <= 1'b0;
        end else begin
            fcs_q <= fcs_err;
        end
    end

    always_comb begin
        bad_frame = frame_end && frame_crc_err;
        is_short  = (frame_len < MIN_L);
        is_long   = (frame_len > MAX_L);
        cnt_ev            = '0;
        cnt_ev[CNT_FRAG]  = bad_frame && is_short;
        cnt_ev[CNT_JAB]   = bad_frame && is_long;
        cnt_ev[CNT_FCS]   = fcs_err && !fcs_q;
    end

endmodule

// File: rtl/rx_stat_counter.sv
module rx_stat_counter #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/rx_stat_snapshot.sv
module rx_stat_snapshot
    import rx_stat_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             snap_set,
    input  logic                             snap_rel,
    input  logic [NUM_CNT-1:0][CNT_W-1:0]    live_cnt,
    output logic [NUM_CNT-1:0][CNT_W-1:0]    shadow_cnt,
    output logic                             use_shadow
);

    snap_state_e state;
    snap_state_e state_nxt;
    logic        capture;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= SNAP_LIVE;
        end else begin
            state <= state_nxt;
        end
    end

    // Next state
    always_comb begin
        state_nxt = state;
        unique case (state)
            SNAP_LIVE:   if (snap_set) state_nxt = SNAP_FROZEN;
            SNAP_FROZEN: if (snap_rel) state_nxt = SNAP_LIVE;
            default:     state_nxt = SNAP_LIVE;
        endcase
    end

    // Outputs
    always_comb begin
        capture    = 1'b0;
        use_shadow = 1'b0;
        unique case (state)
            SNAP_LIVE:   capture    = snap_set;
            SNAP_FROZEN: use_shadow = 1'b1;
            default:     use_shadow = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow_cnt <= '0;
        end else if (capture) begin
            shadow_cnt <= live_cnt;
        end
    end

endmodule

// File: rtl/rx_stat_regs.sv
module rx_stat_regs
    import rx_stat_pkg::*;
#(
    parameter int CNT_W    = 64,
    parameter bit STATS_EN = 1'b1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             reg_wr,
    input  logic                             reg_rd,
    input  logic [ADDR_W-1:0]                reg_addr,
    input  logic [DATA_W-1:0]                reg_wdata,
    input  logic [NUM_CNT-1:0][CNT_W-1:0]    live_cnt,
    input  logic [NUM_CNT-1:0][CNT_W-1:0]    shadow_cnt,
    input  logic                             use_shadow,
    output logic [DATA_W-1:0]                reg_rdata,
    output logic                             clr_all,
    output logic                             snap_set,
    output logic                             snap_rel
);

    localparam int BLK_LSB = 3;

    logic                 cfg_snap;
    logic                 cfg_hit;
    logic                 cnt_hit;
    logic [BLK_LSB-1:0]   offs;
    logic [1:0]           sel_idx;
    logic [READ_W-1:0]    sel_val;
    logic [DATA_W-1:0]    rd_val;
    logic                 unused_wdata;

    assign unused_wdata = ^{reg_wdata[DATA_W-1:CFG_SNAP_BIT+1], reg_wdata[CFG_SNAP_BIT-1:CFG_CLR_BIT+1]};

    assign cfg_hit  = (reg_addr == ADDR_CFG);
    assign clr_all  = reg_wr && cfg_hit && reg_wdata[CFG_CLR_BIT];
    assign snap_set = reg_wr && cfg_hit &&  reg_wdata[CFG_SNAP_BIT] && !cfg_snap;
    assign snap_rel = reg_wr && cfg_hit && !reg_wdata[CFG_SNAP_BIT] &&  cfg_snap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_snap <= 1'b0;
        end else if (reg_wr && cfg_hit) begin
            cfg_snap <= reg_wdata[CFG_SNAP_BIT];
        end
    end

    assign offs    = reg_addr[BLK_LSB-1:0];
    assign sel_idx = offs[2:1];
    assign cnt_hit = (reg_addr[ADDR_W-1:BLK_LSB] == ADDR_CNT_BASE[ADDR_W-1:BLK_LSB])
                     && (sel_idx < 2'(NUM_CNT));

    generate
        if (STATS_EN) begin : g_on
            always_comb begin
                sel_val = '0;
                if (cnt_hit) begin
                    if (use_shadow) sel_val[CNT_W-1:0] = shadow_cnt[sel_idx];
                    else            sel_val[CNT_W-1:0] = live_cnt[sel_idx];
                end
            end
        end else begin : g_off
            logic unused_cnt;
            assign unused_cnt = ^{live_cnt, shadow_cnt, use_shadow, cnt_hit};
            assign sel_val    = '0;
        end
    endgenerate

    always_comb begin
        rd_val = '0;
        if (cfg_hit) begin
            rd_val[CFG_SNAP_BIT] = cfg_snap;
        end else if (offs[0]) begin
            rd_val = sel_val[READ_W-1:DATA_W];
        end else begin
            rd_val = sel_val[DATA_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            reg_rdata <= rd_val;
        end
    end

endmodule

// File: rtl/rx_stat_bank.sv
module rx_stat_bank
    import rx_stat_pkg::*;
#(
    parameter int CNT_W    = 64,
    parameter int LEN_W    = 16,
    parameter int MIN_LEN  = 64,
    parameter int MAX_LEN  = 1518,
    parameter bit STATS_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_end,
    input  logic [LEN_W-1:0]  frame_len,
    input  logic              frame_crc_err,
    input  logic              fcs_err,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [11:0]       reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata
);

    logic [NUM_CNT-1:0]               cnt_ev;
    logic [NUM_CNT-1:0][CNT_W-1:0]    live_cnt;
    logic [NUM_CNT-1:0][CNT_W-1:0]    shadow_cnt;
    logic                             use_shadow;
    logic                             clr_all;
    logic                             snap_set;
    logic                             snap_rel;

    generate
        if (STATS_EN) begin : g_stats
            rx_stat_classify #(
                .LEN_W   (LEN_W),
                .MIN_LEN (MIN_LEN),
                .MAX_LEN (MAX_LEN)
            ) u_classify (
                .clk           (clk),
                .rst_n         (rst_n),
                .frame_end     (frame_end),
                .frame_len     (frame_len),
                .frame_crc_err (frame_crc_err),
                .fcs_err       (fcs_err),
                .cnt_ev        (cnt_ev)
            );

            for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
                rx_stat_counter #(
                    .CNT_W (CNT_W)
                ) u_cnt (
                    .clk   (clk),
                    .rst_n (rst_n),
                    .clr   (clr_all),
                    .inc   (cnt_ev[i]),
                    .cnt   (live_cnt[i])
                );
            end

            rx_stat_snapshot #(
                .CNT_W (CNT_W)
            ) u_snap (
                .clk        (clk),
                .rst_n      (rst_n),
                .snap_set   (snap_set),
                .snap_rel   (snap_rel),
                .live_cnt   (live_cnt),
                .shadow_cnt (shadow_cnt),
                .use_shadow (use_shadow)
            );
        end else begin : g_nostats
            logic unused_in;
            assign unused_in  = ^{frame_end, frame_len, frame_crc_err, fcs_err, snap_set, snap_rel};
            assign cnt_ev     = '0;
            assign live_cnt   = '0;
            assign shadow_cnt = '0;
            assign use_shadow = 1'b0;
        end
    endgenerate

    rx_stat_regs #(
        .CNT_W    (CNT_W),
        .STATS_EN (STATS_EN)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_rd     (reg_rd),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .live_cnt   (live_cnt),
        .shadow_cnt (shadow_cnt),
        .use_shadow (use_shadow),
        .reg_rdata  (reg_rdata),
        .clr_all    (clr_all),
        .snap_set   (snap_set),
        .snap_rel   (snap_rel)
    );

endmodule

// File: rtl/rx_stat_bank_chk.sv
module rx_stat_bank_chk
    import rx_stat_pkg::*;
#(
    parameter int CNT_W    = 64,
    parameter bit STATS_EN = 1'b1
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             clr_all,
    input logic [NUM_CNT-1:0]               cnt_ev,
    input logic [NUM_CNT-1:0][CNT_W-1:0]    live_cnt,
    input logic [NUM_CNT-1:0][CNT_W-1:0]    shadow_cnt,
    input logic                             use_shadow,
    input logic                             reg_rd,
    input logic [11:0]                      reg_addr,
    input logic [31:0]                      reg_rdata
);

    logic mapped;
    assign mapped = (reg_addr >= 12'h900 && reg_addr <= 12'h905) || (reg_addr == ADDR_CFG);

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_per_cnt
        // R1 R2 R3: an event without clear moves the counter by exactly one (R5: modulo width)
        a_r5_event_step: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_ev[i] && !clr_all) |=> (live_cnt[i] == $past(live_cnt[i]) + CNT_W'(1)));
        // R6: without event or clear the counter holds, whatever is read
        a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (!cnt_ev[i] && !clr_all) |=> $stable(live_cnt[i]));
    end

    // R7: clear wins over any same-cycle event
    a_r7_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all |=> (live_cnt == '0));

    // R8: the frozen copy does not move while the snapshot is held
    a_r8_frozen_stable: assert property (@(posedge clk) disable iff (!rst_n)
        use_shadow |=> (!use_shadow || $stable(shadow_cnt)));

    // R4: unmapped reads return zero
    a_r4_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && !mapped) |=> (reg_rdata == '0));

    generate
        if (!STATS_EN) begin : g_off_chk
            // R10: counter reads in a build without counters return zero
            a_r10_off_zero: assert property (@(posedge clk) disable iff (!rst_n)
                (reg_rd && reg_addr != ADDR_CFG) |=> (reg_rdata == '0));
        end
    endgenerate

endmodule

bind rx_stat_bank rx_stat_bank_chk #(
    .CNT_W    (CNT_W),
    .STATS_EN (STATS_EN)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_all    (clr_all),
    .cnt_ev     (cnt_ev),
    .live_cnt   (live_cnt),
    .shadow_cnt (shadow_cnt),
    .use_shadow (use_shadow),
    .reg_rd     (reg_rd),
    .reg_addr   (reg_addr),
    .reg_rdata  (reg_rdata)
);

// File: tb/rx_stat_bank_tb.sv
`timescale 1ns/1ps
module rx_stat_bank_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_end = 1'b0;
    logic [15:0] frame_len = '0;
    logic        frame_crc_err = 1'b0;
    logic        fcs_err = 1'b0;
    logic        fcs_w = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] rdata_main, rdata_off, rdata_w;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    // Behavioural reference: counts kept as plain integers
    longint unsigned m_frag = 0, m_jab = 0, m_fcs = 0;
    longint unsigned s_frag = 0, s_jab = 0, s_fcs = 0;
    bit              m_frozen = 1'b0;
    logic [31:0]     got_main, got_off, got_w;

    always #2.5 clk = ~clk;

    rx_stat_bank u_dut (
        .clk(clk), .rst_n(rst_n), .frame_end(frame_end), .frame_len(frame_len),
        .frame_crc_err(frame_crc_err), .fcs_err(fcs_err), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rdata_main)
    );

    rx_stat_bank #(.STATS_EN(1'b0)) u_dut_off (
        .clk(clk), .rst_n(rst_n), .frame_end(frame_end), .frame_len(frame_len),
        .frame_crc_err(frame_crc_err), .fcs_err(fcs_err), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rdata_off)
    );

    rx_stat_bank #(.CNT_W(8)) u_dut_w (
        .clk(clk), .rst_n(rst_n), .frame_end(1'b0), .frame_len(16'd0),
        .frame_crc_err(1'b0), .fcs_err(fcs_w), .reg_wr(1'b0),
        .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(32'd0), .reg_rdata(rdata_w)
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=0x%08h expected=0x%08h", req, what, act, exp);
        end
    endtask

    task automatic rd(input logic [11:0] a);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        got_main = rdata_main; got_off = rdata_off; got_w = rdata_w;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic frame(input int len, input bit crc);
        @(negedge clk);
        frame_end = 1'b1; frame_len = 16'(len); frame_crc_err = crc;
        @(negedge clk);
        frame_end = 1'b0; frame_crc_err = 1'b0;
        if (crc && len < 64)   m_frag++;
        if (crc && len > 1518) m_jab++;
    endtask

    task automatic fcs_pulse(input int width);
        @(negedge clk);
        fcs_err = 1'b1;
        repeat (width) @(negedge clk);
        fcs_err = 1'b0;
        m_fcs++;
    endtask

    function automatic longint unsigned view(input int idx);
        if (idx == 0) return m_frozen ? s_frag : m_frag;
        if (idx == 1) return m_frozen ? s_jab  : m_jab;
        return m_frozen ? s_fcs : m_fcs;
    endfunction

    task automatic check_all(input string req);
        for (int k = 0; k < 3; k++) begin
            longint unsigned v;
            v = view(k);
            rd(12'h900 + 12'(2*k));
            check(req, $sformatf("counter %0d low", k), got_main, v[31:0]);
            rd(12'h901 + 12'(2*k));
            check(req, $sformatf("counter %0d high", k), got_main, v[63:32]);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11: reset state
        check_all("R11");
        rd(12'h945);
        check("R11", "config after reset", got_main, 32'h0);

        // R1: fragment classification around MIN_LEN
        frame(63, 1'b1);
        frame(63, 1'b0);
        frame(64, 1'b1);
        frame(20, 1'b1);
        rd(12'h900);
        check("R1", "fragments 63/err,63/ok,64/err,20/err", got_main, 32'd2);

        // R2: jabber classification around MAX_LEN
        frame(1519, 1'b1);
        frame(1518, 1'b1);
        frame(2000, 1'b0);
        frame(9000, 1'b1);
        rd(12'h902);
        check("R2", "jabbers 1519/err,1518/err,2000/ok,9000/err", got_main, 32'd2);
        rd(12'h900);
        check("R2", "long frames leave fragments", got_main, 32'd2);

        // R3: one count per pulse irrespective of width
        fcs_pulse(1);
        fcs_pulse(5);
        fcs_pulse(1);
        rd(12'h904);
        check("R3", "fcs after widths 1,5,1", got_main, 32'd3);

        // R4: full map, high halves and unmapped words
        check_all("R4");
        rd(12'h906);
        check("R4", "unmapped 0x906", got_main, 32'h0);
        rd(12'h946);
        check("R4", "unmapped 0x946", got_main, 32'h0);

        // R6: repeated reads do not change a count
        rd(12'h902);
        rd(12'h902);
        check("R6", "jabbers after repeated reads", got_main, 32'(m_jab));

        // R10: disabled build reads zero
        rd(12'h900);
        check("R10", "disabled fragments", got_off, 32'h0);
        rd(12'h904);
        check("R10", "disabled fcs", got_off, 32'h0);

        // R8: snapshot holds while live counters move
        wr(12'h945, 32'h4);
        m_frozen = 1'b1; s_frag = m_frag; s_jab = m_jab; s_fcs = m_fcs;
        frame(10, 1'b1);
        frame(3000, 1'b1);
        fcs_pulse(2);
        check_all("R8");
        rd(12'h945);
        check("R8", "snapshot bit readback", got_main, 32'h4);

        // R9: release shows live counts including frozen-period events
        wr(12'h945, 32'h0);
        m_frozen = 1'b0;
        check_all("R9");

        // R7: clear, and clear against a same-cycle fragment event
        @(negedge clk);
        frame_end = 1'b1; frame_len = 16'd10; frame_crc_err = 1'b1;
        reg_wr = 1'b1; reg_addr = 12'h945; reg_wdata = 32'h1;
        @(negedge clk);
        frame_end = 1'b0; frame_crc_err = 1'b0; reg_wr = 1'b0;
        m_frag = 0; m_jab = 0; m_fcs = 0;
        check_all("R7");
        rd(12'h945);
        check("R7", "clear bit reads back zero", got_main, 32'h0);
        frame(5, 1'b1);
        rd(12'h900);
        check("R7", "counting resumes after clear", got_main, 32'd1);

        // R5: wrap on an 8-bit build after 257 pulses
        for (int k = 0; k < 257; k++) begin
            @(negedge clk); fcs_w = 1'b1;
            @(negedge clk); fcs_w = 1'b0;
        end
        rd(12'h904);
        check("R5", "8-bit counter wrapped", got_w, 32'd1);
        rd(12'h905);
        check("R5", "8-bit counter high word", got_w, 32'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog (all requirements): actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule